// File: doc/BRIEF.md
# Frame-Sync Locked Clock Prescaler

This block runs on the master clock. It counts master-clock cycles between rising edges of the frame-sync input to work out which of seven supported master frequencies is present: 256, 512, 1536, 1544, 2048, 2560 or 4096 kHz. Once two frames in a row give the same count, it sets a divider. The divider produces two single-cycle enables: a 256 kHz enable, which fires 32 times per frame, and an 8 kHz sample enable, which fires once per frame. The 1544 kHz case gives 193 cycles per frame. It is handled by making the last of the 32 periods one cycle longer.

The same block also decides the power state. It drops into standby in two cases: when frame sync stays quiet for longer than the detected frame plus a margin, or when the power-up input is low. To leave standby, the power-up input must be high and a frame-sync pulse must arrive. After waking, the serial transmit permit stays low until two more frame-sync pulses have been seen. The frame-sync input is assumed to be synchronous to the master clock.

Top module: `fsp_prescaler`

## Requirements
- R1: After reset, rate_code_o is 7, powered_o and tx_permit_o are 0, and no enable fires.
- R2: A frame count exactly equal to 32, 64, 192, 193, 256, 320 or 512 selects rate code 0, 1, 2, 3, 4, 5 or 6 respectively.
- R3: A count that matches no nominal value exactly, but lies within ±1 of one, selects the lowest code within that window. For example, 33 gives 0, 63 gives 1, 191 gives 2 and 194 gives 3.
- R4: A count farther than ±1 from every nominal value sets rate_code_o to 7, and both enables stay silent.
- R5: The rate code changes only when two consecutive frame measurements are identical. A single frame of a new length leaves it unchanged.
- R6: While a rate is locked, each sample-enable period holds exactly 32 fast enables. The sample-enable period equals the nominal count of the locked code, including 193 for code 3.
- R7: Suppose no new frame-sync edge comes within the nominal count of the locked rate (or 512 when none is locked) plus 8 cycles. Then the block powers down. It stays powered while the count since the edge has not yet exceeded that limit.
- R8: A low power-up input forces standby one cycle later, and frame-sync pulses cannot wake the block while that input stays low.
- R9: From standby, powered_o rises in the cycle after a frame-sync edge that arrives while the power-up input is high. Without such an edge it stays low.
- R10: After waking, tx_permit_o stays low through the first frame-sync edge and rises in the cycle after the second.
- R11: In standby, both enables are silent and rate_code_o returns to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | Frame sync, one pulse per 8 kHz frame, synchronous to clk_i |
| pwr_up_i | input | 1 | Power-up request; low forces standby |
| clk256_en_o | output | 1 | 256 kHz clock enable, 32 per frame |
| smp8k_en_o | output | 1 | 8 kHz sample enable, one per frame |
| rate_code_o | output | 3 | Detected master rate code 0..6, 7 when none |
| powered_o | output | 1 | High outside standby |
| tx_permit_o | output | 1 | High when the serial transmit output may drive |

## Verification
Frame periods at every nominal count test whether each count selects its own code and its own enable spacing. The 193-cycle frame shows whether the one stretched period is placed so that exactly 32 enables still fit in a frame. Periods one cycle off nominal (33, 63, 191, 194) test the tolerance window and its tie-breaking toward the lower code, and a 100-cycle period tests rejection of an unsupported rate. Walking the frame length downward, changing it for a single frame, stopping frame sync, and pulling the power-up input low show apart the lock rule, the loss margin and the two-frame transmit hold-off.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
   // number of supported master rates and their code width
   localparam int NUM_RATES = 7;
   localparam int CODE_W    = 3;
   localparam logic [CODE_W-1:0] CODE_NONE = 3'd7;

   // fast enables per frame (256 kHz / 8 kHz)
   localparam int SLOTS = 32;

   // master cycles per frame for each rate code, in code order
   localparam int NOMINAL [NUM_RATES] = '{32, 64, 192, 193, 256, 320, 512};
   localparam int MAX_NOMINAL = 512;

   typedef enum logic [1:0] {
      PW_DOWN   = 2'd0,
      PW_WAKE   = 2'd1,
      PW_ACTIVE = 2'd2
   } pwr_state_t;
endpackage

// File: rtl/fsp_period_meter.sv
module fsp_period_meter #(
   parameter int CNT_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             fsync_i,
   input  logic             clear_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             edge_o,
   output logic             stable_o,
   output logic [CNT_W-1:0] stable_cnt_o,
   output logic             loss_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             fs_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] prev_q;
   logic             seen_q;
   logic             prev_ok_q;

   assign edge_o = fsync_i & ~fs_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fs_q      <= 1'b0;
         cnt_q     <= '0;
         prev_q    <= '0;
         seen_q    <= 1'b0;
         prev_ok_q <= 1'b0;
      end else begin
         fs_q <= fsync_i;
         // cycles since the last edge, saturating
         if (edge_o)
            cnt_q <= CNT_W'(1);
         else if (cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
         // an edge marks the start of a measurable frame
         if (edge_o)
            seen_q <= 1'b1;
         else if (clear_i)
            seen_q <= 1'b0;
         if (clear_i)
            prev_ok_q <= 1'b0;
         else if (edge_o && seen_q) begin
            prev_ok_q <= 1'b1;
            prev_q    <= cnt_q;
         end
      end
   end

   assign stable_o     = edge_o && seen_q && !clear_i && prev_ok_q && (cnt_q == prev_q);
   assign stable_cnt_o = cnt_q;
   assign loss_o       = cnt_q > limit_i;

   // R7
   edge_clears_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_o |=> !loss_o);
endmodule

// File: rtl/fsp_rate_match.sv
module fsp_rate_match
   import fsp_pkg::*;
#(
   parameter int CNT_W = 10,
   parameter int TOL   = 1
) (
   input  logic [CNT_W-1:0]  count_i,
   output logic [CODE_W-1:0] code_o
);
   logic [NUM_RATES-1:0] hit_exact;
   logic [NUM_RATES-1:0] hit_near;

   for (genvar i = 0; i < NUM_RATES; i++) begin : g_cmp
      localparam logic [CNT_W-1:0] NOM = CNT_W'(NOMINAL[i]);
      localparam logic [CNT_W-1:0] LO  = CNT_W'(NOMINAL[i] - TOL);
      localparam logic [CNT_W-1:0] HI  = CNT_W'(NOMINAL[i] + TOL);
      assign hit_exact[i] = (count_i == NOM);
      assign hit_near[i]  = (count_i >= LO) && (count_i <= HI);
   end

   // exact hit wins; otherwise the lowest code inside the window
   always_comb begin
      code_o = CODE_NONE;
      for (int i = NUM_RATES - 1; i >= 0; i--) begin
         if (hit_near[i]) code_o = CODE_W'(i);
      end
      for (int i = NUM_RATES - 1; i >= 0; i--) begin
         if (hit_exact[i]) code_o = CODE_W'(i);
      end
   end
endmodule

// File: rtl/fsp_enable_gen.sv
module fsp_enable_gen
   import fsp_pkg::*;
#(
   parameter int DIV_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             restart_i,
   input  logic [DIV_W-1:0] base_i,
   input  logic [DIV_W-1:0] extra_i,
   output logic             clk256_en_o,
   output logic             smp_en_o
);
   localparam int SLOT_W = $clog2(SLOTS);

   logic [DIV_W-1:0]  div_q;
   logic [SLOT_W-1:0] slot_q;
   logic              last_slot;
   logic [DIV_W-1:0]  len;

   assign last_slot = (slot_q == SLOT_W'(SLOTS - 1));
   // the final slot of a frame absorbs the leftover cycles
   assign len = base_i + (last_slot ? extra_i : '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q  <= '0;
         slot_q <= '0;
      end else if (!run_i || restart_i) begin
         div_q  <= '0;
         slot_q <= '0;
      end else if (div_q == len - 1'b1) begin
         div_q  <= '0;
         slot_q <= last_slot ? '0 : slot_q + 1'b1;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   assign clk256_en_o = run_i && (div_q == '0);
   assign smp_en_o    = clk256_en_o && (slot_q == '0);

   // R6
   fast_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clk256_en_o && (base_i > DIV_W'(1)) && !restart_i) |=> !clk256_en_o);
   // R6
   smp_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp_en_o && !restart_i) |=> !smp_en_o);
endmodule

// File: rtl/fsp_power_ctl.sv
module fsp_power_ctl
   import fsp_pkg::*;
#(
   parameter int WAKE_FRAMES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pwr_up_i,
   input  logic edge_i,
   input  logic loss_i,
   output logic powered_o,
   output logic tx_permit_o
);
   localparam int WK_W = $clog2(WAKE_FRAMES + 1);

   pwr_state_t       state_q;
   logic [WK_W-1:0]  wcnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= PW_DOWN;
         wcnt_q  <= '0;
      end else if (!pwr_up_i) begin
         state_q <= PW_DOWN;
      end else begin
         unique case (state_q)
            PW_DOWN: begin
               if (edge_i) begin
                  state_q <= PW_WAKE;
                  wcnt_q  <= '0;
               end
            end
            PW_WAKE: begin
               if (loss_i)
                  state_q <= PW_DOWN;
               else if (edge_i) begin
                  if (wcnt_q == WK_W'(WAKE_FRAMES - 1))
                     state_q <= PW_ACTIVE;
                  else
                     wcnt_q <= wcnt_q + 1'b1;
               end
            end
            PW_ACTIVE: begin
               if (loss_i) state_q <= PW_DOWN;
            end
            default: state_q <= PW_DOWN;
         endcase
      end
   end

   assign powered_o   = (state_q != PW_DOWN);
   assign tx_permit_o = (state_q == PW_ACTIVE);

   // R8
   pwr_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pwr_up_i |=> !powered_o);
   // R9
   wake_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(powered_o) |-> $past(edge_i && pwr_up_i));
   // R10
   tx_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(tx_permit_o) |-> $past(edge_i));
   // R7
   loss_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (loss_i && powered_o) |=> !powered_o);
endmodule

// File: rtl/fsp_prescaler.sv
module fsp_prescaler
   import fsp_pkg::*;
#(
   parameter int CNT_W       = 10,
   parameter int TOL         = 1,
   parameter int LOSS_MARGIN = 8,
   parameter int WAKE_FRAMES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              fsync_i,
   input  logic              pwr_up_i,
   output logic              clk256_en_o,
   output logic              smp8k_en_o,
   output logic [CODE_W-1:0] rate_code_o,
   output logic              powered_o,
   output logic              tx_permit_o
);
   localparam int DIV_W = $clog2(MAX_NOMINAL / SLOTS + SLOTS);

   logic              fs_edge;
   logic              stable;
   logic [CNT_W-1:0]  stable_cnt;
   logic              loss;
   logic [CNT_W-1:0]  limit;
   logic [CODE_W-1:0] match_code;
   logic [CODE_W-1:0] rate_q;
   logic              restart;
   logic              run;
   logic [DIV_W-1:0]  base;
   logic [DIV_W-1:0]  extra;

   fsp_period_meter #(.CNT_W(CNT_W)) meter_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .fsync_i      (fsync_i),
      .clear_i      (!powered_o),
      .limit_i      (limit),
      .edge_o       (fs_edge),
      .stable_o     (stable),
      .stable_cnt_o (stable_cnt),
      .loss_o       (loss)
   );

   fsp_rate_match #(.CNT_W(CNT_W), .TOL(TOL)) match_i (
      .count_i (stable_cnt),
      .code_o  (match_code)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         rate_q <= CODE_NONE;
      else if (!powered_o)
         rate_q <= CODE_NONE;
      else if (stable)
         rate_q <= match_code;
   end

   // divider settings and loss limit for the locked rate
   always_comb begin
      base  = '0;
      extra = '0;
      limit = CNT_W'(MAX_NOMINAL + LOSS_MARGIN);
      for (int i = 0; i < NUM_RATES; i++) begin
         if (rate_q == CODE_W'(i)) begin
            base  = DIV_W'(NOMINAL[i] / SLOTS);
            extra = DIV_W'(NOMINAL[i] % SLOTS);
            limit = CNT_W'(NOMINAL[i] + LOSS_MARGIN);
         end
      end
   end

   assign restart = stable && powered_o && (match_code != rate_q);
   assign run     = powered_o && (rate_q != CODE_NONE);

   fsp_enable_gen #(.DIV_W(DIV_W)) gen_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (run),
      .restart_i   (restart),
      .base_i      (base),
      .extra_i     (extra),
      .clk256_en_o (clk256_en_o),
      .smp_en_o    (smp8k_en_o)
   );

   fsp_power_ctl #(.WAKE_FRAMES(WAKE_FRAMES)) pwr_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pwr_up_i    (pwr_up_i),
      .edge_i      (fs_edge),
      .loss_i      (loss),
      .powered_o   (powered_o),
      .tx_permit_o (tx_permit_o)
   );

   assign rate_code_o = rate_q;

   // R11
   standby_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !powered_o |-> (!clk256_en_o && !smp8k_en_o));
   // R4
   none_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rate_code_o == CODE_NONE) |-> !clk256_en_o);
   // R5
   rate_by_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (powered_o && $past(powered_o) && (rate_code_o != $past(rate_code_o))) |-> $past(stable));
endmodule

// File: tb/fsp_prescaler_tb_top.sv
module fsp_prescaler_tb_top;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       fsync;
   logic       pwr_up;
   logic       clk256_en;
   logic       smp8k_en;
   logic [2:0] rate_code;
   logic       powered;
   logic       tx_permit;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // monitor state
   int cyc = 0;
   int last_smp = 0;
   int smp_period = 0;
   int en_cnt = 0;
   int en_per_frame = 0;
   int en_total = 0;

   always #4 clk = ~clk;

   fsp_prescaler dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .fsync_i     (fsync),
      .pwr_up_i    (pwr_up),
      .clk256_en_o (clk256_en),
      .smp8k_en_o  (smp8k_en),
      .rate_code_o (rate_code),
      .powered_o   (powered),
      .tx_permit_o (tx_permit)
   );

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (clk256_en) begin
         en_total = en_total + 1;
         if (smp8k_en) begin
            smp_period   = cyc - last_smp;
            last_smp     = cyc;
            en_per_frame = en_cnt;
            en_cnt       = 1;
         end else begin
            en_cnt = en_cnt + 1;
         end
      end
   end

   task automatic check(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic frames(input int p, input int n);
      for (int k = 0; k < n; k++) begin
         fsync = 1'b1;
         @(negedge clk);
         fsync = 1'b0;
         repeat (p - 1) @(negedge clk);
      end
   endtask

   task automatic t_reset();
      check("R1 rate code after reset", int'(rate_code), 7);
      check("R1 powered after reset", int'(powered), 0);
      check("R1 tx permit after reset", int'(tx_permit), 0);
      check("R1 enables after reset", en_total, 0);
   endtask

   task automatic t_wake();
      repeat (20) @(negedge clk);
      check("R9 no wake without frame pulse", int'(powered), 0);
      frames(512, 1);
      check("R9 powered after first pulse", int'(powered), 1);
      check("R10 tx held after wake pulse", int'(tx_permit), 0);
      frames(512, 1);
      check("R10 tx held after one more pulse", int'(tx_permit), 0);
      frames(512, 1);
      check("R10 tx permitted after two pulses", int'(tx_permit), 1);
      check("R2 code for 512", int'(rate_code), 6);
      frames(512, 2);
      check("R6 sample period at 512", smp_period, 512);
      check("R6 fast enables per frame at 512", en_per_frame, 32);
   endtask

   task automatic t_lock_hold();
      frames(320, 2);
      check("R5 code held after one new frame", int'(rate_code), 6);
      frames(320, 3);
      check("R5 code after two equal frames", int'(rate_code), 5);
      check("R6 sample period at 320", smp_period, 320);
      check("R6 fast enables per frame at 320", en_per_frame, 32);
   endtask

   task automatic t_rate(input string req, input int p, input int code, input int period);
      frames(p, 5);
      check({req, " rate code"}, int'(rate_code), code);
      if (period > 0) begin
         check("R6 sample period", smp_period, period);
         check("R6 fast enables per frame", en_per_frame, 32);
      end
   endtask

   task automatic t_unsupported();
      int snap;
      frames(100, 5);
      check("R4 code for count 100", int'(rate_code), 7);
      snap = en_total;
      frames(100, 1);
      check("R4 no enables at unsupported rate", en_total - snap, 0);
      check("R4 still powered at unsupported rate", int'(powered), 1);
   endtask

   task automatic t_loss();
      int snap;
      fsync = 1'b1;
      @(negedge clk);
      fsync = 1'b0;
      repeat (39) @(negedge clk);
      check("R7 powered inside loss margin", int'(powered), 1);
      repeat (4) @(negedge clk);
      check("R7 standby after loss margin", int'(powered), 0);
      check("R7 tx dropped on loss", int'(tx_permit), 0);
      check("R11 rate code cleared in standby", int'(rate_code), 7);
      snap = en_total;
      repeat (50) @(negedge clk);
      check("R11 enables silent in standby", en_total - snap, 0);
   endtask

   task automatic t_pwr_low();
      frames(32, 3);
      check("R10 tx permitted after rewake", int'(tx_permit), 1);
      check("R2 code for 32 after rewake", int'(rate_code), 0);
      pwr_up = 1'b0;
      @(negedge clk);
      check("R8 standby one cycle after power-up low", int'(powered), 0);
      check("R8 tx dropped on power-up low", int'(tx_permit), 0);
      frames(32, 3);
      check("R8 frame pulses ignored while power-up low", int'(powered), 0);
      pwr_up = 1'b1;
      frames(32, 1);
      check("R9 wake with power-up high and pulse", int'(powered), 1);
      check("R10 tx held after wake pulse", int'(tx_permit), 0);
      frames(32, 1);
      check("R10 tx held after one more pulse", int'(tx_permit), 0);
      frames(32, 1);
      check("R10 tx permitted after second pulse", int'(tx_permit), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n  = 1'b0;
      fsync  = 1'b0;
      pwr_up = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_wake();
      t_lock_hold();
      t_rate("R2 count 256", 256, 4, 256);
      t_rate("R3 count 194", 194, 3, 193);
      t_rate("R2 count 193", 193, 3, 193);
      t_rate("R2 count 192", 192, 2, 192);
      t_rate("R3 count 191", 191, 2, 0);
      t_unsupported();
      t_rate("R2 count 64", 64, 1, 64);
      t_rate("R3 count 63", 63, 1, 0);
      t_rate("R3 count 33", 33, 0, 0);
      t_rate("R2 count 32", 32, 0, 32);
      t_loss();
      t_pwr_low();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule